// File: doc/BRIEF.md
# Exact posit product accumulator

This block is a wide fixed-point accumulator that sums exact posit products without any rounding. Each cycle it can take one unrounded product, given as a sign bit, a biased exponent and a significand. The exponent places the operand at a bit position in the accumulator. The operand is then added to, or subtracted from, the running total. Arithmetic wraps modulo the numeric width, and bits shifted above that width are discarded.

The stored word is as wide as the accumulator. Its top bit is a sticky Not-a-Real (NaR) flag, which takes the place of one carry-guard bit. The remaining bits hold the numeric total in two's complement. A NaR operand sets the flag. While the flag is set, further operands do not change the total. A synchronous clear empties everything in one cycle.

The adder can be split into segments with registered carries between them, which keeps the carry chain short. In that mode a carry still in flight means the raw word is not yet the true total. A readout-valid output shows when every inter-segment carry register is empty.

Top module: `posit_quire`

## Requirements
- R1: After reset `acc_o` is all zero and `valid_o` is high.
- R2: When `acc_i` is high, `nar_i` is low and the NaR flag is clear, the numeric bits `acc_o[ACC_W-2:0]` become the old total plus V shifted left by `exp_i`, modulo 2^(ACC_W-1). V is the two's-complement value `{sign_i, sig_i}` sign-extended. The new total is visible once `valid_o` is high.
- R3: When `sub_i` is also high, the shifted V is subtracted instead of added.
- R4: When `acc_i` is low, `sub_i`, `nar_i`, `sign_i`, `exp_i` and `sig_i` have no effect. With `valid_o` high, `acc_o` stays unchanged.
- R5: `acc_i` high together with `nar_i` high sets the NaR flag `acc_o[ACC_W-1]` on the next edge. The NaR operand's significand is not added.
- R6: Once set, the NaR flag stays set until a clear, and the numeric total no longer changes.
- R7: `clr_i` high zeroes the numeric bits, the NaR flag and all pending carries in one cycle. It takes priority over `acc_i`.
- R8: In segmented mode, `valid_o` is low while any inter-segment carry is pending. For example, adding 1 to a total of all ones leaves `valid_o` low for NSEG-1 cycles.
- R9: After NSEG-1 consecutive cycles without a numeric accumulate, `valid_o` is high.
- R10: In unsegmented mode, `valid_o` is always high and each result is visible one cycle after its operand.
- R11: Operand bits shifted to positions at or above ACC_W-1 are dropped. For example, `sig_i`=3 with `exp_i`=126 adds only 2^126.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of total, NaR flag and carries |
| acc_i | input | 1 | Accumulate the operand this cycle |
| sub_i | input | 1 | Subtract instead of add |
| nar_i | input | 1 | Operand is NaR |
| sign_i | input | 1 | Sign bit of the product significand |
| exp_i | input | EXP_W | Biased exponent: left shift applied to the operand |
| sig_i | input | SIG_W | Low bits of the two's-complement product significand |
| acc_o | output | ACC_W | Raw accumulator word: NaR flag in the MSB, numeric total below |
| valid_o | output | 1 | No inter-segment carry pending; numeric bits are the true total |

## Verification
The bench builds two copies of the block side by side with default widths: 16-bit posits, a 128-bit word, a 28-bit significand and a 7-bit exponent. The first copy uses 32-bit segments, which splits the 127 numeric bits into four segments, the last one 31 bits wide. The all-ones-plus-one case therefore drives a carry through every carry register and out of the shorter top segment, where it is discarded. The second copy is unsegmented. It exposes the same stimulus with a result on every cycle, so any value mismatch there is seen right away rather than only after the carries settle.

// File: rtl/posit_quire_pkg.sv
package posit_quire_pkg;
  function automatic int seg_count(input int num_w, input int seg_w);
    return (num_w + seg_w - 1) / seg_w;
  endfunction
endpackage

// File: rtl/quire_align.sv
module quire_align #(
  parameter int NUM_W = 127,
  parameter int SIG_W = 28,
  parameter int EXP_W = 7
) (
  input  logic             en_i,
  input  logic             sub_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [NUM_W-1:0] op_o,
  output logic             cin_o
);
  logic [NUM_W-1:0] ext;
  logic [NUM_W-1:0] shifted;

  assign ext     = {{(NUM_W-SIG_W){sign_i}}, sig_i};
  assign shifted = ext << exp_i;
  // subtract: invert here, +1 enters as carry-in of the lowest segment
  assign op_o    = en_i ? (sub_i ? ~shifted : shifted) : '0;
  assign cin_o   = en_i & sub_i;
endmodule

// File: rtl/quire_seg_add.sv
module quire_seg_add #(
  parameter int NUM_W = 127,
  parameter int SEG_W = 32,
  parameter int NSEG  = 4
) (
  input  logic [NUM_W-1:0] acc_i,
  input  logic [NUM_W-1:0] op_i,
  input  logic             cin_i,
  input  logic [NSEG-1:0]  cy_i,
  output logic [NUM_W-1:0] sum_o,
  output logic [NSEG-1:0]  cy_o
);
  assign cy_o[0] = 1'b0;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int LO = k * SEG_W;
    localparam int W  = (NUM_W - LO < SEG_W) ? (NUM_W - LO) : SEG_W;
    logic cin_k;

    if (k == 0) begin : g_first
      assign cin_k = cin_i | cy_i[0];
    end else begin : g_mid
      assign cin_k = cy_i[k];
    end

    if (k == NSEG - 1) begin : g_top
      // carry out of the top segment is dropped: modular total
      assign sum_o[LO +: W] = acc_i[LO +: W] + op_i[LO +: W] + W'(cin_k);
    end else begin : g_low
      logic [W:0] s;
      assign s = {1'b0, acc_i[LO +: W]} + {1'b0, op_i[LO +: W]} + (W+1)'(cin_k);
      assign sum_o[LO +: W] = s[W-1:0];
      assign cy_o[k+1]      = s[W];
    end
  end
endmodule

// File: rtl/posit_quire.sv
module posit_quire
  import posit_quire_pkg::*;
#(
  parameter int POSIT_W   = 16,
  parameter int ACC_W     = POSIT_W * POSIT_W / 2,
  parameter int SIG_W     = 28,
  parameter int EXP_W     = 7,
  parameter bit SEGMENTED = 1'b1,
  parameter int SEG_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic             sub_i,
  input  logic             nar_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             valid_o
);
  localparam int NUM_W = ACC_W - 1;
  localparam int EFF_W = SEGMENTED ? SEG_W : NUM_W;
  localparam int NSEG  = seg_count(NUM_W, EFF_W);

  logic [NUM_W-1:0] num_q, num_d, op;
  logic [NSEG-1:0]  cy_q, cy_d;
  logic             nar_q, cin, add_en;

  assign add_en = acc_i & ~nar_i & ~nar_q;

  quire_align #(.NUM_W(NUM_W), .SIG_W(SIG_W), .EXP_W(EXP_W)) u_align (
    .en_i  (add_en),
    .sub_i (sub_i),
    .sign_i(sign_i),
    .exp_i (exp_i),
    .sig_i (sig_i),
    .op_o  (op),
    .cin_o (cin)
  );

  quire_seg_add #(.NUM_W(NUM_W), .SEG_W(EFF_W), .NSEG(NSEG)) u_add (
    .acc_i(num_q),
    .op_i (op),
    .cin_i(cin),
    .cy_i (cy_q),
    .sum_o(num_d),
    .cy_o (cy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      cy_q  <= '0;
      nar_q <= 1'b0;
    end else if (clr_i) begin
      num_q <= '0;
      cy_q  <= '0;
      nar_q <= 1'b0;
    end else begin
      num_q <= num_d;
      cy_q  <= cy_d;
      if (acc_i && nar_i) nar_q <= 1'b1;
    end
  end

  assign acc_o   = {nar_q, num_q};
  assign valid_o = ~|cy_q;
endmodule

// File: rtl/posit_quire_chk.sv
module posit_quire_chk #(
  parameter int ACC_W = 128,
  parameter int NSEG  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             acc_i,
  input logic             nar_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             valid_o
);
  int unsigned idle_q;
  logic        num_acc;

  assign num_acc = acc_i & ~nar_i & ~acc_o[ACC_W-1] & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idle_q <= NSEG - 1;
    else if (clr_i)             idle_q <= NSEG - 1;
    else if (num_acc)           idle_q <= 0;
    else if (idle_q < NSEG - 1) idle_q <= idle_q + 1;
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !acc_i && !clr_i |=> $stable(acc_o) && valid_o);

  // R5
  nar_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && nar_i && !clr_i |=> acc_o[ACC_W-1]);

  // R6
  nar_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o[ACC_W-1] && !clr_i |=> acc_o[ACC_W-1]);

  // R6
  nar_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o[ACC_W-1] && valid_o && !clr_i |=> $stable(acc_o));

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0) && valid_o);

  // R9
  settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q >= NSEG - 1 |-> valid_o);

  // R5
  nar_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_o[ACC_W-1] && !(acc_i && nar_i) |=> !acc_o[ACC_W-1]);
endmodule

bind posit_quire posit_quire_chk #(.ACC_W(ACC_W), .NSEG(NSEG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .acc_i  (acc_i),
  .nar_i  (nar_i),
  .acc_o  (acc_o),
  .valid_o(valid_o)
);

// File: tb/posit_quire_bench.sv
module posit_quire_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 128;
  localparam int NUM_W      = ACC_W - 1;
  localparam int SIG_W      = 28;
  localparam int EXP_W      = 7;
  localparam int NSEG       = (NUM_W + 31) / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, acc = 1'b0, sub = 1'b0, nar = 1'b0, sign = 1'b0;
  logic [EXP_W-1:0] exp_v = '0;
  logic [SIG_W-1:0] sig = '0;
  logic [ACC_W-1:0] acc_s, acc_f;
  logic             valid_s, valid_f;

  logic [NUM_W-1:0] mval = '0;
  bit               mnar = 1'b0;
  int               idle = NSEG - 1;
  int               n_chk = 0, n_fail = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  posit_quire u_posit_quire (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .acc_i(acc), .sub_i(sub),
    .nar_i(nar), .sign_i(sign), .exp_i(exp_v), .sig_i(sig),
    .acc_o(acc_s), .valid_o(valid_s)
  );

  posit_quire #(.SEGMENTED(1'b0)) u_posit_quire_flat (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .acc_i(acc), .sub_i(sub),
    .nar_i(nar), .sign_i(sign), .exp_i(exp_v), .sig_i(sig),
    .acc_o(acc_f), .valid_o(valid_f)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [ACC_W-1:0] exp_word;
    exp_word = {mnar, mval};
    check(acc_s[ACC_W-1] == mnar, "R5/R6 nar flag (segmented)", {127'd0, acc_s[ACC_W-1]}, {127'd0, mnar});
    check(acc_f[ACC_W-1] == mnar, "R5/R6 nar flag (flat)", {127'd0, acc_f[ACC_W-1]}, {127'd0, mnar});
    if (idle >= NSEG - 1)
      check(valid_s == 1'b1, "R9 valid after settle", {127'd0, valid_s}, 128'd1);
    if (valid_s)
      check(acc_s == exp_word, {tag, " segmented value"}, acc_s, exp_word);
    check(valid_f == 1'b1, "R10 flat valid", {127'd0, valid_f}, 128'd1);
    check(acc_f == exp_word, {tag, " R10 flat value"}, acc_f, exp_word);
  endtask

  task automatic step(input bit c, input bit a, input bit s, input bit n, input bit sg,
                      input logic [EXP_W-1:0] e, input logic [SIG_W-1:0] g,
                      input string tag);
    logic [NUM_W-1:0] term;
    bit eff;
    clr = c; acc = a; sub = s; nar = n; sign = sg; exp_v = e; sig = g;
    @(posedge clk);
    eff  = a && !n && !mnar && !c;
    term = {{(NUM_W-SIG_W){sg}}, g};
    term = term << e;
    if (c) begin
      mval = '0; mnar = 1'b0; idle = NSEG - 1;
    end else begin
      if (a && n) mnar = 1'b1;
      if (eff) begin
        mval = s ? (mval - term) : (mval + term);
        idle = 0;
      end else if (idle < NSEG - 1) begin
        idle++;
      end
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle_step(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(acc_s == '0 && valid_s, "R1 reset segmented", acc_s, '0);
    check(acc_f == '0 && valid_f, "R1 reset flat", acc_f, '0);

    // R2 plain adds
    step(0, 1, 0, 0, 0, 7'd0, 28'd5, "R2");
    step(0, 1, 0, 0, 0, 7'd40, 28'h0ABCDEF, "R2");
    step(0, 1, 0, 0, 1, 7'd3, 28'h0000010, "R2");
    repeat (NSEG) idle_step("R2");
    // R3 subtract
    step(0, 1, 1, 0, 0, 7'd60, 28'h1234567, "R3");
    step(0, 1, 1, 0, 1, 7'd10, 28'hFFFFF00, "R3");
    repeat (NSEG) idle_step("R3");
    // R4 ignored inputs when acc_i low
    step(0, 0, 1, 1, 1, 7'd90, 28'hFFFFFFF, "R4");
    check(acc_s[ACC_W-1] == 1'b0, "R4 nar not set without acc", acc_s, '0);
    step(0, 0, 0, 0, 0, 7'd5, 28'h7777777, "R4");

    // R7 clear beats accumulate
    step(1, 1, 0, 0, 0, 7'd0, 28'd9, "R7");
    check(acc_s == '0 && acc_f == '0, "R7 clear priority", acc_s, '0);

    // R8 all ones then +1: carry ripples through every segment
    step(0, 1, 1, 0, 0, 7'd0, 28'd1, "R8");
    repeat (NSEG) idle_step("R8");
    check(acc_s == {1'b0, {NUM_W{1'b1}}}, "R8 all ones", acc_s, {1'b0, {NUM_W{1'b1}}});
    step(0, 1, 0, 0, 0, 7'd0, 28'd1, "R8");
    check(valid_s == 1'b0, "R8 carry pending c0", {127'd0, valid_s}, 128'd0);
    for (int i = 1; i < NSEG - 1; i++) begin
      idle_step("R8");
      check(valid_s == 1'b0, "R8 carry pending", {127'd0, valid_s}, 128'd0);
    end
    idle_step("R9");
    check(valid_s == 1'b1 && acc_s == '0, "R9 settled to zero", acc_s, '0);

    // R11 high bits dropped
    step(0, 1, 0, 0, 0, 7'd126, 28'd3, "R11");
    repeat (NSEG) idle_step("R11");
    check(acc_s == {2'b01, 126'd0}, "R11 truncation", acc_s, {2'b01, 126'd0});

    // R5 / R6 NaR behaviour
    step(0, 1, 0, 1, 0, 7'd2, 28'd100, "R5");
    step(0, 1, 0, 0, 0, 7'd4, 28'd77, "R6");
    step(0, 1, 1, 0, 1, 7'd9, 28'd3, "R6");
    repeat (NSEG) idle_step("R6");
    check(acc_s == {2'b11, 126'd0}, "R6 frozen total", acc_s, {2'b11, 126'd0});
    step(1, 0, 0, 0, 0, '0, '0, "R7");
    check(acc_s == '0 && valid_s, "R7 clear drops nar", acc_s, '0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 200;
      step(r < 3, ($urandom % 4) != 0, $urandom % 2, r == 3 || r == 4, $urandom % 2,
           EXP_W'($urandom), SIG_W'($urandom), "R2");
    end
    repeat (NSEG) idle_step("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule